// File: doc/BRIEF.md
# Multi-Cycle Integer Datapath

This block is the datapath of a small multi-cycle integer processor. It runs add, sub, and, or, slt, lw, sw, beq and j over a 32-entry register file. One memory port serves both instruction fetch and data access. One ALU does the arithmetic, the address sums and the program-counter arithmetic. Each phase leaves its result in an internal holding register: the instruction register, the two operand registers, the ALU result register and the loaded-data register. A later phase then picks the result up from there.

The datapath holds no sequencing of its own. An external controller drives a set of per-cycle steering and write-enable signals. The datapath returns the opcode and function fields of the held instruction, and the controller decides the next step from them.

A usual controller spends the following cycles:
- Every instruction uses a fetch cycle and then a decode cycle.
- Branches and jumps finish in their third cycle.
- Arithmetic instructions and stores finish in their fourth cycle.
- Loads finish in their fifth cycle.

The memory port has an address, write data, a write strobe and read data. The memory is expected to return read data in the same cycle as the address, and to write on the rising clock edge.

Top module: `mcd_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter is cleared to 0. After reset, with `addr_sel`=0, `mem_addr` reads 0.
- R2: With `addr_sel`=0 the memory address is the program counter. A fetch cycle uses these controls: `a_sel`=0, `b_sel`=1 (constant 4), `alu_op`=0 (add), `pc_src`=0, `pc_wr`=1. It advances the program counter by 4. With `pc_wr`=0 and `pc_wr_eq`=0 the program counter holds.
- R3: When `ir_wr`=1 the fetched word is captured at the edge, and `opcode` shows bits 31:26 and `funct` shows bits 5:0 from the next cycle. When `ir_wr`=0 the held instruction does not change.
- R4: For an instruction with opcode 0, `alu_op`=2 selects the operation from `funct`: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than. The result is written to the register named by bits 15:11 when `rf_we`=1, `dst_sel`=1 and `wb_sel`=0.
- R5: Register 0 always reads as zero, and writes aimed at it have no effect.
- R6: With `b_sel`=2 the ALU adds the sign-extended low 16 bits, giving the load/store address. A load writes the word captured from memory one cycle after the access into the register named by bits 20:16 (`dst_sel`=0, `wb_sel`=1).
- R7: With `addr_sel`=1 the memory address is the held ALU result. During a store, `mem_wdata` is the second operand register, read from bits 20:16.
- R8: The decode cycle uses `a_sel`=0 and `b_sel`=3. It holds the branch target, PC+4 plus the sign-extended offset shifted left by two, in the ALU result register. With `pc_wr_eq`=1, `pc_src`=1 and `alu_op`=1, the program counter takes that target only if the two operand registers are equal.
- R9: With `pc_src`=2 and `pc_wr`=1, the program counter becomes the upper 4 bits of the current program counter (already PC+4), followed by bits 25:0 of the instruction shifted left by two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_wr | input | 1 | Unconditional program counter write |
| pc_wr_eq | input | 1 | Program counter write if operands are equal |
| addr_sel | input | 1 | Memory address: 0 program counter, 1 ALU result register |
| ir_wr | input | 1 | Capture the memory word as the instruction |
| rf_we | input | 1 | Register file write enable |
| dst_sel | input | 1 | Destination: 0 bits 20:16, 1 bits 15:11 |
| wb_sel | input | 1 | Write-back data: 0 ALU result register, 1 loaded-data register |
| a_sel | input | 1 | ALU first input: 0 program counter, 1 operand A |
| b_sel | input | 2 | ALU second input: 0 operand B, 1 constant 4, 2 offset, 3 offset shifted by 2 |
| alu_op | input | 2 | 0 add, 1 subtract, 2 from funct field |
| pc_src | input | 2 | Next PC: 0 ALU output, 1 ALU result register, 2 jump target |
| mem_rdata | input | 32 | Memory read data (same cycle) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| opcode | output | 6 | Opcode field of the held instruction |
| funct | output | 6 | Function field of the held instruction |

## Verification
Assertions inside the RTL check on every cycle the rules that need no program:
- the instruction register and program counter hold when not enabled;
- a conditional branch with unequal operands leaves the program counter alone;
- the loaded-data register follows the memory;
- an enabled register write lands.

Only the bench's directed program can show the rest:
- the results of the five ALU functions;
- sign-extended load offsets, including negative ones;
- store addresses and data;
- taken, untaken and backward branch targets;
- the jump target;
- the fact that register 0 cannot be written.

The bench acts as both the controller and the memory, and it tracks every fetch address against the program order it expects.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

    localparam int XLEN = 32;

    typedef enum logic [1:0] {
        OPSEL_ADD   = 2'd0,
        OPSEL_SUB   = 2'd1,
        OPSEL_FUNCT = 2'd2,
        OPSEL_RSVD  = 2'd3
    } opsel_e;

    typedef enum logic [2:0] {
        FN_ADD,
        FN_SUB,
        FN_AND,
        FN_OR,
        FN_SLT
    } alu_fn_e;

    typedef enum logic [1:0] {
        BSRC_REG    = 2'd0,
        BSRC_FOUR   = 2'd1,
        BSRC_OFS    = 2'd2,
        BSRC_BRANCH = 2'd3
    } bsrc_e;

    typedef enum logic [1:0] {
        NPC_ALU    = 2'd0,
        NPC_HELD   = 2'd1,
        NPC_JUMP   = 2'd2,
        NPC_RSVD   = 2'd3
    } npc_e;

    typedef struct packed {
        logic [5:0]  op;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [4:0]  rd;
        logic [4:0]  sh;
        logic [5:0]  fn;
    } instr_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic alu_fn_e decode_fn(input opsel_e sel, input logic [5:0] f);
        alu_fn_e r;
        r = FN_ADD;
        case (sel)
            OPSEL_SUB:   r = FN_SUB;
            OPSEL_FUNCT: begin
                case (f)
                    6'h22:   r = FN_SUB;
                    6'h24:   r = FN_AND;
                    6'h25:   r = FN_OR;
                    6'h2A:   r = FN_SLT;
                    default: r = FN_ADD;
                endcase
            end
            default:     r = FN_ADD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mcd_alu.sv
module mcd_alu
    import mcd_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_fn_e        fn,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y,
    output logic           zero
);
    always_comb begin
        case (fn)
            FN_SUB:  y = a - b;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/mcd_regfile.sv
module mcd_regfile #(
    parameter int W     = 32,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (we && wa != '0) regs[wa] <= wd;
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

    // R4 / R6: an enabled write to a nonzero register is readable next cycle
    a_r4_write_lands: assert property (@(posedge clk) disable iff (rst)
        (we && wa != '0) |=> (regs[$past(wa)] == $past(wd)));
endmodule

// File: rtl/mcd_core.sv
module mcd_core
    import mcd_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pc_wr,
    input  logic            pc_wr_eq,
    input  logic            addr_sel,
    input  logic            ir_wr,
    input  logic            rf_we,
    input  logic            dst_sel,
    input  logic            wb_sel,
    input  logic            a_sel,
    input  logic [1:0]      b_sel,
    input  logic [1:0]      alu_op,
    input  logic [1:0]      pc_src,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic [5:0]      opcode,
    output logic [5:0]      funct
);
    logic [XLEN-1:0] pc_q, opa_q, opb_q, res_q, mdr_q, pc_d;
    instr_t          ir_q;
    logic [XLEN-1:0] rd1, rd2, alu_a, alu_b, alu_y, wb_data;
    logic [XLEN-1:0] ofs, jump_tgt;
    logic            alu_zero, pc_en;
    logic [AW-1:0]   wa;
    alu_fn_e         fn;

    assign ofs      = sext16({ir_q.rd, ir_q.sh, ir_q.fn});
    assign jump_tgt = {pc_q[XLEN-1:XLEN-4], ir_q.rs, ir_q.rt, ir_q.rd, ir_q.sh, ir_q.fn, 2'b00};

    // operand steering
    assign alu_a = a_sel ? opa_q : pc_q;
    always_comb begin
        case (bsrc_e'(b_sel))
            BSRC_FOUR:   alu_b = XLEN'(4);
            BSRC_OFS:    alu_b = ofs;
            BSRC_BRANCH: alu_b = {ofs[XLEN-3:0], 2'b00};
            default:     alu_b = opb_q;
        endcase
    end

    assign fn = decode_fn(opsel_e'(alu_op), ir_q.fn);

    mcd_alu #(.W(XLEN)) u_alu (
        .fn   (fn),
        .a    (alu_a),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign wa      = AW'(dst_sel ? ir_q.rd : ir_q.rt);
    assign wb_data = wb_sel ? mdr_q : res_q;

    mcd_regfile #(.W(XLEN), .NREGS(NREGS)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (AW'(ir_q.rs)),
        .ra2 (AW'(ir_q.rt)),
        .rd1 (rd1),
        .rd2 (rd2),
        .we  (rf_we),
        .wa  (wa),
        .wd  (wb_data)
    );

    // next program counter
    always_comb begin
        case (npc_e'(pc_src))
            NPC_HELD: pc_d = res_q;
            NPC_JUMP: pc_d = jump_tgt;
            default:  pc_d = alu_y;
        endcase
    end
    assign pc_en = pc_wr | (pc_wr_eq & alu_zero);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ir_q  <= '0;
            opa_q <= '0;
            opb_q <= '0;
            res_q <= '0;
            mdr_q <= '0;
        end else begin
            if (pc_en) pc_q <= pc_d;
            if (ir_wr) ir_q <= mem_rdata;
            opa_q <= rd1;
            opb_q <= rd2;
            res_q <= alu_y;
            mdr_q <= mem_rdata;
        end
    end

    assign mem_addr  = addr_sel ? res_q : pc_q;
    assign mem_wdata = opb_q;
    assign opcode    = ir_q.op;
    assign funct     = ir_q.fn;

    // R3: held instruction does not change without ir_wr
    a_r3_ir_hold: assert property (@(posedge clk) disable iff (rst)
        !ir_wr |=> $stable(ir_q));
    // R2: program counter holds when neither write is requested
    a_r2_pc_hold: assert property (@(posedge clk) disable iff (rst)
        (!pc_wr && !pc_wr_eq) |=> $stable(pc_q));
    // R8: unequal operands on a conditional write leave the PC alone
    a_r8_branch_not_taken: assert property (@(posedge clk) disable iff (rst)
        (pc_wr_eq && !pc_wr && alu_op == 2'd1 && a_sel && b_sel == 2'd0 && opa_q != opb_q)
        |=> $stable(pc_q));
    // R6: loaded-data register follows memory one cycle later
    a_r6_mdr_capture: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (mdr_q == $past(mem_rdata)));
endmodule

// File: tb/test_mcd_core.sv
module test_mcd_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pc_wr, pc_wr_eq, addr_sel, ir_wr, rf_we, dst_sel, wb_sel, a_sel;
    logic [1:0]  b_sel, alu_op, pc_src;
    logic [31:0] mem_rdata, mem_addr, mem_wdata;
    logic [5:0]  opcode, funct;

    logic [31:0] mem [256];
    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    mcd_core i_mcd_core (
        .clk(clk), .rst(rst), .pc_wr(pc_wr), .pc_wr_eq(pc_wr_eq),
        .addr_sel(addr_sel), .ir_wr(ir_wr), .rf_we(rf_we), .dst_sel(dst_sel),
        .wb_sel(wb_sel), .a_sel(a_sel), .b_sel(b_sel), .alu_op(alu_op),
        .pc_src(pc_src), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .opcode(opcode), .funct(funct)
    );

    assign mem_rdata = mem[mem_addr[9:2]];
    always @(posedge clk) if (addr_sel && ir_wr == 1'b0 && mem_we_q) mem[mem_addr[9:2]] <= mem_wdata;

    logic mem_we_q = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] f);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, f};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic idle();
        pc_wr = 0; pc_wr_eq = 0; addr_sel = 0; ir_wr = 0; rf_we = 0;
        dst_sel = 0; wb_sel = 0; a_sel = 0; b_sel = 0; alu_op = 0; pc_src = 0;
        mem_we_q = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    // one instruction driven by the bench acting as controller
    task automatic step(input logic [31:0] exp_pc);
        logic [31:0] word;
        word = mem[exp_pc[9:2]];
        #1;
        check(mem_addr == exp_pc, "R2 fetch address", mem_addr, exp_pc);
        ir_wr = 1; b_sel = 2'd1; pc_wr = 1;
        tick();
        check(opcode == word[31:26] && funct == word[5:0], "R3 opcode/funct",
              {20'd0, opcode, funct}, {20'd0, word[31:26], word[5:0]});
        b_sel = 2'd3;
        tick();
        case (opcode)
            6'h23, 6'h2B: begin
                a_sel = 1; b_sel = 2'd2;
                tick();
                addr_sel = 1; mem_we_q = (opcode == 6'h2B);
                if (opcode == 6'h23) begin
                    tick();
                    rf_we = 1; wb_sel = 1; dst_sel = 0;
                end
                tick();
            end
            6'h00: begin
                a_sel = 1; alu_op = 2'd2;
                tick();
                rf_we = 1; dst_sel = 1;
                tick();
            end
            6'h04: begin
                a_sel = 1; alu_op = 2'd1; pc_wr_eq = 1; pc_src = 2'd1;
                tick();
            end
            default: begin
                pc_wr = 1; pc_src = 2'd2;
                tick();
            end
        endcase
    endtask

    task automatic load_program();
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        mem[0]  = enc_i(6'h23, 0, 1, 16'h0100);
        mem[1]  = enc_i(6'h23, 0, 2, 16'h0104);
        mem[2]  = enc_r(1, 2, 3, 6'h20);
        mem[3]  = enc_r(1, 2, 4, 6'h22);
        mem[4]  = enc_r(1, 2, 5, 6'h24);
        mem[5]  = enc_r(1, 2, 6, 6'h25);
        mem[6]  = enc_r(2, 1, 7, 6'h2A);
        mem[7]  = enc_r(1, 2, 8, 6'h2A);
        for (int k = 0; k < 6; k++) mem[8+k] = enc_i(6'h2B, 0, 3+k, 16'(16'h0200 + 4*k));
        mem[14] = enc_r(1, 2, 0, 6'h20);
        mem[15] = enc_i(6'h2B, 0, 0, 16'h0218);
        mem[16] = enc_i(6'h04, 1, 2, 16'd5);
        mem[17] = enc_i(6'h04, 1, 1, 16'd2);
        mem[18] = enc_i(6'h2B, 0, 1, 16'h021C);
        mem[19] = enc_i(6'h2B, 0, 1, 16'h021C);
        mem[20] = {6'h02, 26'h18};
        for (int k = 21; k < 24; k++) mem[k] = enc_i(6'h2B, 0, 1, 16'h0220);
        mem[24] = enc_i(6'h23, 0, 10, 16'h0108);
        mem[25] = enc_i(6'h23, 10, 9, 16'hFFFC);
        mem[26] = enc_i(6'h2B, 10, 9, 16'h0014);
        mem[27] = enc_i(6'h04, 0, 0, 16'hFFFF);
        mem[64] = 32'd7;
        mem[65] = 32'd5;
        mem[66] = 32'h210;
        mem[32'h21C >> 2] = 32'hDEAD;
        mem[32'h220 >> 2] = 32'hDEAD;
        mem[32'h218 >> 2] = 32'hFFFF;
    endtask

    task automatic test_reset();
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        check(mem_addr == 32'h0, "R1 reset PC", mem_addr, 32'h0);
    endtask

    task automatic test_run_program();
        for (int a = 0; a <= 32'h44; a += 4) step(32'(a));
        step(32'h50);   // R8 taken forward branch landed here
        step(32'h60);   // R9 jump target
        step(32'h64);
        step(32'h68);
        step(32'h6C);
        step(32'h6C);   // R8 backward branch to itself
    endtask

    task automatic test_alu_results();
        check(mem[32'h200>>2] == 32'd12, "R4 add", mem[32'h200>>2], 32'd12);
        check(mem[32'h204>>2] == 32'd2,  "R4 sub", mem[32'h204>>2], 32'd2);
        check(mem[32'h208>>2] == 32'd5,  "R4 and", mem[32'h208>>2], 32'd5);
        check(mem[32'h20C>>2] == 32'd7,  "R4 or",  mem[32'h20C>>2], 32'd7);
        check(mem[32'h210>>2] == 32'd1,  "R4 slt true",  mem[32'h210>>2], 32'd1);
        check(mem[32'h214>>2] == 32'd0,  "R4 slt false", mem[32'h214>>2], 32'd0);
    endtask

    task automatic test_memory_and_flow();
        check(mem[32'h218>>2] == 32'd0, "R5 register 0 stays zero", mem[32'h218>>2], 32'd0);
        check(mem[32'h224>>2] == 32'd7, "R6/R7 negative offset load then store",
              mem[32'h224>>2], 32'd7);
        check(mem[32'h21C>>2] == 32'hDEAD, "R8 skipped by taken branch",
              mem[32'h21C>>2], 32'hDEAD);
        check(mem[32'h220>>2] == 32'hDEAD, "R9 skipped by jump",
              mem[32'h220>>2], 32'hDEAD);
    endtask

    initial begin
        load_program();
        test_reset();
        test_run_program();
        test_alu_results();
        test_memory_and_flow();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule